// File: doc/BRIEF.md
# Unit-Granular Byte-Lane Order Bridge

This block connects a 64-bit interconnect to a peripheral whose byte lanes are fixed in little-endian order. The interconnect's endianness is a strap picked at boot. When the system runs little-endian, the bridge forwards every transaction unchanged. When it runs big-endian, the bridge reverses the order of the data units inside each transaction. A unit is 8, 16 or 32 bits wide, and the bytes inside a unit keep their order. The result is that the peripheral finds its data units on the same lanes whatever the system's endianness.

The block has two independent paths, each with a valid/ready handshake that carries a data word and its byte enables. The write path runs from the interconnect to the peripheral. The read path runs from the peripheral back to the interconnect. Both paths use the same lane mapping, so data written and then read back through the bridge comes back as it was written. Each path adds one register stage, and the data is reordered before that register.

Top module: `lane_order_bridge`

## Requirements
- R1: With `cfg_big_endian` low, data and byte enables leave both paths exactly as they entered, whatever `cfg_unit` holds.
- R2: With `cfg_big_endian` high and `cfg_unit` = 0 (8-bit units), output byte lane i carries input byte lane 7-i.
- R3: With `cfg_big_endian` high and `cfg_unit` = 1 (16-bit units), the four 2-byte groups come out in reverse group order, and the two bytes inside each group keep their order.
- R4: With `cfg_big_endian` high and `cfg_unit` = 2 (32-bit units), bits 31:0 and bits 63:32 are exchanged, and byte order inside each half is unchanged.
- R5: `cfg_unit` = 3 names a 64-bit unit. One such unit fills the whole transaction, so data passes unchanged even when `cfg_big_endian` is high.
- R6: Byte-enable bit j follows byte lane j through the same mapping as the data.
- R7: The read path applies the same mapping as the write path, so a word written through the bridge and returned unmodified by the peripheral reads back as the original word.
- R8: A transfer accepted at a clock edge shows on the output of its path immediately after that edge, one cycle of latency.
- R9: While an output is valid and not ready, it holds valid, data and byte enables steady. The input is ready whenever the stage is empty or its output is being taken. Every accepted transfer leaves exactly once, in order.
- R10: During synchronous reset, and right after it, both outputs are not valid and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Boot-time system endianness, 1 = big-endian |
| cfg_unit | input | 2 | Swap-unit size: 0=8, 1=16, 2=32, 3=64 bits |
| up_wr_valid | input | 1 | Write transfer valid from interconnect |
| up_wr_ready | output | 1 | Bridge can take a write transfer |
| up_wr_data | input | 64 | Write data from interconnect |
| up_wr_be | input | 8 | Write byte enables from interconnect |
| dn_wr_valid | output | 1 | Write transfer valid to peripheral |
| dn_wr_ready | input | 1 | Peripheral takes the write transfer |
| dn_wr_data | output | 64 | Reordered write data |
| dn_wr_be | output | 8 | Reordered write byte enables |
| dn_rd_valid | input | 1 | Read return valid from peripheral |
| dn_rd_ready | output | 1 | Bridge can take a read return |
| dn_rd_data | input | 64 | Read data from peripheral |
| dn_rd_be | input | 8 | Read byte enables from peripheral |
| up_rd_valid | output | 1 | Read return valid to interconnect |
| up_rd_ready | input | 1 | Interconnect takes the read return |
| up_rd_data | output | 64 | Reordered read data |
| up_rd_be | output | 8 | Reordered read byte enables |

## Verification
The block's internal state is small: an index into the lane mapping, and a single occupied flag with its payload in each direction. A bad lane index shows on the output the very next cycle as a byte or enable sitting on the wrong lane. Each swap mode is therefore compared against a reference that splits the word into units and reverses them, on every transfer. A wrong occupied flag shows either as a transfer that never arrives or as one that arrives twice. The bench catches this by keeping an ordered queue per path, which underflows or is left non-empty after a drain. Stalls are injected at random so that a payload changing while the output waits is detected within one cycle.

// File: rtl/lane_order_pkg.sv
package lane_order_pkg;

  typedef enum logic [1:0] {
    UNIT_8  = 2'd0,
    UNIT_16 = 2'd1,
    UNIT_32 = 2'd2,
    UNIT_64 = 2'd3
  } unit_e;

  // Source lane feeding destination lane dst: units of 2**ulog bytes are
  // reversed in order, the offset within a unit is kept.
  function automatic int src_lane(input int dst, input int ulog,
                                  input int lanes, input bit big);
    int ub;
    int off;
    ub = 1 << ulog;
    if (!big || ub >= lanes) return dst;
    off = dst % ub;
    return lanes - ub - (dst - off) + off;
  endfunction

endpackage

// File: rtl/lane_permute.sv
module lane_permute #(
  parameter int LANES = 8,
  parameter int LANE_W = 8
) (
  input  logic                      big,
  input  logic [1:0]                unit,
  input  logic [LANES*LANE_W-1:0]   data_i,
  input  logic [LANES-1:0]          be_i,
  output logic [LANES*LANE_W-1:0]   data_o,
  output logic [LANES-1:0]          be_o
);
  import lane_order_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    int src;
    always_comb begin
      src = src_lane(g, int'(unit), LANES, big);
      data_o[g*LANE_W +: LANE_W] = data_i[src*LANE_W +: LANE_W];
      be_o[g] = be_i[src];
    end
  end

endmodule

// File: rtl/reg_slice.sv
module reg_slice #(
  parameter int W = 72
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) out_data <= in_data;
  end

endmodule

// File: rtl/lane_order_bridge.sv
module lane_order_bridge #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_big_endian,
  input  logic [1:0]                 cfg_unit,
  input  logic                       up_wr_valid,
  output logic                       up_wr_ready,
  input  logic [DATA_W-1:0]          up_wr_data,
  input  logic [DATA_W/LANE_W-1:0]   up_wr_be,
  output logic                       dn_wr_valid,
  input  logic                       dn_wr_ready,
  output logic [DATA_W-1:0]          dn_wr_data,
  output logic [DATA_W/LANE_W-1:0]   dn_wr_be,
  input  logic                       dn_rd_valid,
  output logic                       dn_rd_ready,
  input  logic [DATA_W-1:0]          dn_rd_data,
  input  logic [DATA_W/LANE_W-1:0]   dn_rd_be,
  output logic                       up_rd_valid,
  input  logic                       up_rd_ready,
  output logic [DATA_W-1:0]          up_rd_data,
  output logic [DATA_W/LANE_W-1:0]   up_rd_be
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int PW = DATA_W + LANES;

  logic [DATA_W-1:0] wr_pd, rd_pd;
  logic [LANES-1:0]  wr_pb, rd_pb;

  lane_permute #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_perm (
    .big(cfg_big_endian), .unit(cfg_unit),
    .data_i(up_wr_data), .be_i(up_wr_be),
    .data_o(wr_pd), .be_o(wr_pb)
  );

  reg_slice #(.W(PW)) u_wr_slice (
    .clk(clk), .rst(rst),
    .in_valid(up_wr_valid), .in_ready(up_wr_ready), .in_data({wr_pb, wr_pd}),
    .out_valid(dn_wr_valid), .out_ready(dn_wr_ready), .out_data({dn_wr_be, dn_wr_data})
  );

  lane_permute #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_perm (
    .big(cfg_big_endian), .unit(cfg_unit),
    .data_i(dn_rd_data), .be_i(dn_rd_be),
    .data_o(rd_pd), .be_o(rd_pb)
  );

  reg_slice #(.W(PW)) u_rd_slice (
    .clk(clk), .rst(rst),
    .in_valid(dn_rd_valid), .in_ready(dn_rd_ready), .in_data({rd_pb, rd_pd}),
    .out_valid(up_rd_valid), .out_ready(up_rd_ready), .out_data({up_rd_be, up_rd_data})
  );

endmodule

// File: rtl/lane_order_bridge_chk.sv
module lane_order_bridge_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_big_endian,
  input logic [1:0]               cfg_unit,
  input logic                     up_wr_valid,
  input logic                     up_wr_ready,
  input logic [DATA_W-1:0]        up_wr_data,
  input logic [DATA_W/LANE_W-1:0] up_wr_be,
  input logic                     dn_wr_valid,
  input logic                     dn_wr_ready,
  input logic [DATA_W-1:0]        dn_wr_data,
  input logic [DATA_W/LANE_W-1:0] dn_wr_be,
  input logic                     dn_rd_valid,
  input logic                     dn_rd_ready,
  input logic [DATA_W-1:0]        dn_rd_data,
  input logic [DATA_W/LANE_W-1:0] dn_rd_be,
  input logic                     up_rd_valid,
  input logic                     up_rd_ready,
  input logic [DATA_W-1:0]        up_rd_data,
  input logic [DATA_W/LANE_W-1:0] up_rd_be
);

  logic wr_acc, rd_acc;
  assign wr_acc = up_wr_valid && up_wr_ready;
  assign rd_acc = dn_rd_valid && dn_rd_ready;

  // R1: little-endian pass-through on both paths
  a_r1_wr_bypass: assert property (@(posedge clk) disable iff (rst)
    wr_acc && !cfg_big_endian |=> dn_wr_data == $past(up_wr_data) && dn_wr_be == $past(up_wr_be));
  a_r1_rd_bypass: assert property (@(posedge clk) disable iff (rst)
    rd_acc && !cfg_big_endian |=> up_rd_data == $past(dn_rd_data) && up_rd_be == $past(dn_rd_be));

  // R2, R6: full byte reversal of data and enables
  a_r2_byte_rev: assert property (@(posedge clk) disable iff (rst)
    wr_acc && cfg_big_endian && cfg_unit == 2'd0 |=>
      dn_wr_data == {<<LANE_W{$past(up_wr_data)}} && dn_wr_be == {<<{$past(up_wr_be)}});

  if (DATA_W == 64) begin : g_half
    // R4: halves exchanged for 32-bit units
    a_r4_half_swap: assert property (@(posedge clk) disable iff (rst)
      wr_acc && cfg_big_endian && cfg_unit == 2'd2 |=>
        dn_wr_data == {$past(up_wr_data[31:0]), $past(up_wr_data[63:32])});
  end

  // R5: a single 64-bit unit leaves the word unchanged
  a_r5_whole_unit: assert property (@(posedge clk) disable iff (rst)
    wr_acc && cfg_unit == 2'd3 |=> dn_wr_data == $past(up_wr_data));

  // R8: one cycle latency
  a_r8_wr_latency: assert property (@(posedge clk) disable iff (rst) wr_acc |=> dn_wr_valid);
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (rst) rd_acc |=> up_rd_valid);

  // R9: stalled outputs hold, empty stage accepts
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (rst)
    dn_wr_valid && !dn_wr_ready |=> dn_wr_valid && $stable(dn_wr_data) && $stable(dn_wr_be));
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    up_rd_valid && !up_rd_ready |=> up_rd_valid && $stable(up_rd_data) && $stable(up_rd_be));
  a_r9_wr_ready: assert property (@(posedge clk) disable iff (rst) !dn_wr_valid |-> up_wr_ready);
  a_r9_rd_ready: assert property (@(posedge clk) disable iff (rst) !up_rd_valid |-> dn_rd_ready);

  // R10: empty after reset
  a_r10_reset: assert property (@(posedge clk) rst |=> !dn_wr_valid && !up_rd_valid);

endmodule

bind lane_order_bridge lane_order_bridge_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian), .cfg_unit(cfg_unit),
  .up_wr_valid(up_wr_valid), .up_wr_ready(up_wr_ready), .up_wr_data(up_wr_data), .up_wr_be(up_wr_be),
  .dn_wr_valid(dn_wr_valid), .dn_wr_ready(dn_wr_ready), .dn_wr_data(dn_wr_data), .dn_wr_be(dn_wr_be),
  .dn_rd_valid(dn_rd_valid), .dn_rd_ready(dn_rd_ready), .dn_rd_data(dn_rd_data), .dn_rd_be(dn_rd_be),
  .up_rd_valid(up_rd_valid), .up_rd_ready(up_rd_ready), .up_rd_data(up_rd_data), .up_rd_be(up_rd_be)
);

// File: tb/lane_order_bridge_tb.sv
module lane_order_bridge_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_big_endian = 1'b0;
  logic [1:0] cfg_unit = 2'd0;
  logic up_wr_valid = 1'b0, dn_wr_ready = 1'b0, dn_rd_valid = 1'b0, up_rd_ready = 1'b0;
  logic [63:0] up_wr_data = '0, dn_rd_data = '0;
  logic [7:0] up_wr_be = '0, dn_rd_be = '0;
  logic up_wr_ready, dn_wr_valid, dn_rd_ready, up_rd_valid;
  logic [63:0] dn_wr_data, up_rd_data;
  logic [7:0] dn_wr_be, up_rd_be;

  always #(CLK_P/2) clk = ~clk;

  lane_order_bridge dut_i (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit wr_acc = 0, rd_acc = 0;
  logic [71:0] wq[$];
  logic [71:0] rq[$];
  bit hold_w = 0, hold_r = 0;
  logic [71:0] held_w, held_r;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: cut the word into units of 2**ulog bytes, place them reversed.
  function automatic logic [71:0] ref_map(input logic [63:0] d, input logic [7:0] be,
                                          input bit big, input int ulog);
    logic [63:0] rd;
    logic [7:0] rb;
    int ub, nu;
    ub = 1 << ulog;
    nu = 8 / ub;
    if (!big) return {be, d};
    for (int u = 0; u < nu; u++)
      for (int o = 0; o < ub; o++) begin
        rd[((nu-1-u)*ub+o)*8 +: 8] = d[(u*ub+o)*8 +: 8];
        rb[(nu-1-u)*ub+o] = be[u*ub+o];
      end
    return {rb, rd};
  endfunction

  function automatic string mode_tag();
    if (!cfg_big_endian) return "R1";
    case (cfg_unit)
      2'd0: return "R2/R6";
      2'd1: return "R3/R6";
      2'd2: return "R4/R6";
      default: return "R5";
    endcase
  endfunction

  // Monitor: samples just before each rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst) begin
      wr_acc = 0; rd_acc = 0; hold_w = 0; hold_r = 0;
    end else begin
      if (hold_w) chk(dn_wr_valid && {dn_wr_be, dn_wr_data} == held_w, "R9 write hold",
                      {dn_wr_be, dn_wr_data}, held_w);
      if (hold_r) chk(up_rd_valid && {up_rd_be, up_rd_data} == held_r, "R9 read hold",
                      {up_rd_be, up_rd_data}, held_r);
      if (dn_wr_valid && dn_wr_ready) begin
        if (wq.size() == 0) chk(0, "R9 write duplicate", {dn_wr_be, dn_wr_data}, '0);
        else begin
          logic [71:0] e;
          e = wq.pop_front();
          chk({dn_wr_be, dn_wr_data} == e, mode_tag(), {dn_wr_be, dn_wr_data}, e);
        end
      end
      if (up_rd_valid && up_rd_ready) begin
        if (rq.size() == 0) chk(0, "R9 read duplicate", {up_rd_be, up_rd_data}, '0);
        else begin
          logic [71:0] e;
          e = rq.pop_front();
          chk({up_rd_be, up_rd_data} == e, "R7 read path", {up_rd_be, up_rd_data}, e);
        end
      end
      wr_acc = up_wr_valid && up_wr_ready;
      rd_acc = dn_rd_valid && dn_rd_ready;
      if (wr_acc) wq.push_back(ref_map(up_wr_data, up_wr_be, cfg_big_endian, int'(cfg_unit)));
      if (rd_acc) rq.push_back(ref_map(dn_rd_data, dn_rd_be, cfg_big_endian, int'(cfg_unit)));
      hold_w = dn_wr_valid && !dn_wr_ready;
      held_w = {dn_wr_be, dn_wr_data};
      hold_r = up_rd_valid && !up_rd_ready;
      held_r = {up_rd_be, up_rd_data};
    end
  end

  task automatic traffic(input int cycles, input int pv, input int pr);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!up_wr_valid || wr_acc) begin
        up_wr_valid = ($urandom % 100) < pv;
        up_wr_data = {$urandom, $urandom};
        up_wr_be = 8'($urandom);
      end
      if (!dn_rd_valid || rd_acc) begin
        dn_rd_valid = ($urandom % 100) < pv;
        dn_rd_data = {$urandom, $urandom};
        dn_rd_be = 8'($urandom);
      end
      dn_wr_ready = ($urandom % 100) < pr;
      up_rd_ready = ($urandom % 100) < pr;
    end
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (wr_acc) up_wr_valid = 0;
      if (rd_acc) dn_rd_valid = 0;
      dn_wr_ready = 1; up_rd_ready = 1;
    end
    @(negedge clk);
    chk(wq.size() == 0 && rq.size() == 0, "R9 no loss",
        72'(wq.size() + rq.size()), 72'd0);
  endtask

  // Directed write of one word, checked one cycle after acceptance
  task automatic direct_wr(input logic [63:0] d, input logic [7:0] be,
                           input logic [71:0] exp, input string req);
    @(negedge clk);
    up_wr_valid = 1; up_wr_data = d; up_wr_be = be; dn_wr_ready = 0;
    @(negedge clk);
    up_wr_valid = 0;
    #1;
    chk(dn_wr_valid, "R8 latency", {71'd0, dn_wr_valid}, 72'd1);
    chk({dn_wr_be, dn_wr_data} == exp, req, {dn_wr_be, dn_wr_data}, exp);
    @(negedge clk);
    dn_wr_ready = 1;
    @(negedge clk);
    dn_wr_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dn_wr_valid && !up_rd_valid, "R10 outputs idle in reset",
        {70'd0, dn_wr_valid, up_rd_valid}, 72'd0);
    chk(up_wr_ready && dn_rd_ready, "R10 inputs ready", {70'd0, up_wr_ready, dn_rd_ready}, 72'h3);
    rst = 0;
    @(negedge clk);
    chk(!dn_wr_valid && !up_rd_valid, "R10 idle after reset",
        {70'd0, dn_wr_valid, up_rd_valid}, 72'd0);

    cfg_big_endian = 1;
    cfg_unit = 2'd0;
    direct_wr(64'h8877665544332211, 8'h01, {8'h80, 64'h1122334455667788}, "R2 R6 byte reverse");
    cfg_unit = 2'd1;
    direct_wr(64'h8877665544332211, 8'h01, {8'h40, 64'h2211443366558877}, "R3 R6 group reverse");
    cfg_unit = 2'd2;
    direct_wr(64'h8877665544332211, 8'h01, {8'h10, 64'h4433221188776655}, "R4 R6 half swap");
    cfg_unit = 2'd3;
    direct_wr(64'h8877665544332211, 8'h01, {8'h01, 64'h8877665544332211}, "R5 whole unit");
    cfg_big_endian = 0;
    cfg_unit = 2'd0;
    direct_wr(64'h8877665544332211, 8'h0F, {8'h0F, 64'h8877665544332211}, "R1 bypass");

    // R7 round trip in big-endian 16-bit mode
    cfg_big_endian = 1;
    cfg_unit = 2'd1;
    begin
      logic [71:0] cap;
      @(negedge clk);
      up_wr_valid = 1; up_wr_data = 64'hCAFE0123BEEF4567; up_wr_be = 8'hC3; dn_wr_ready = 1;
      @(negedge clk);
      up_wr_valid = 0;
      #1 cap = {dn_wr_be, dn_wr_data};
      @(negedge clk);
      dn_rd_valid = 1; dn_rd_data = cap[63:0]; dn_rd_be = cap[71:64]; up_rd_ready = 1;
      @(negedge clk);
      dn_rd_valid = 0;
      #1;
      chk({up_rd_be, up_rd_data} == {8'hC3, 64'hCAFE0123BEEF4567}, "R7 round trip",
          {up_rd_be, up_rd_data}, {8'hC3, 64'hCAFE0123BEEF4567});
      @(negedge clk);
    end

    for (int m = 0; m < 5; m++) begin
      cfg_big_endian = (m != 0);
      cfg_unit = (m == 0) ? 2'd2 : 2'(m - 1);
      traffic(300, 70, 60);
      traffic(200, 90, 30);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule